// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts the direction and destination of branches for a dual-pipe integer core. A table of branch records is read with the address of each branch when it leaves the first decode stage. A record is found when its valid bit is set and its stored tag matches the address. If the saturating counter of that record leans towards taken, the block reports a taken prediction with the stored destination on the next cycle. In that same cycle it switches the fetch-stream selector from the linear prefetch buffer to the target prefetch buffer.

When a branch resolves in execute, the block trains the table. It also compares the real outcome with the prediction that travelled down the pipe alongside the branch. On a mismatch it raises a one-cycle flush request with the address to restart fetch from. It also gives a stall length that depends on which integer pipe held the branch. Decode, the caches and the pipeline proper lie outside the block. They are seen only as the lookup and resolve ports.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every record and clears `pred_taken`, `flush`, `stall_cycles` and `fetch_sel`. The first lookup after reset finds no record.
- R2: A lookup uses index `lk_pc[IDX_W+1:2]` and tag `lk_pc[ADDR_W-1:IDX_W+2]`. Its result appears on `pred_taken`/`pred_target` exactly one cycle after `lk_valid`. With `lk_valid` low, `pred_taken` is 0 on the next cycle.
- R3: `pred_taken` is 1 only when the lookup hits a valid record whose 2-bit counter is 2 or 3. `pred_target` is then that record's stored destination.
- R4: A resolved taken branch that misses allocates its record, holding its tag, its destination and counter value 2. A resolved not-taken branch that misses changes nothing, and a record sharing its index stays intact.
- R5: A resolved branch that hits moves the counter up by one if taken or down by one if not, saturating at 3 and 0. A taken hit also rewrites the stored destination with `rs_target`.
- R6: A misprediction occurs when `rs_valid` is high and either `rs_taken` differs from `rs_pred_taken`, or both are 1 and `rs_target` differs from `rs_pred_target`. On the next cycle `flush` is 1 for one cycle and `redirect_pc` is `rs_target` if taken, else `rs_pc + 4`.
- R7: With `flush`, `stall_cycles` is 3 when `rs_pipe` was 0 (first integer pipe) and 4 when it was 1 (second pipe). Without `flush` it is 0.
- R8: `fetch_sel` (1 = target stream, 0 = linear stream) becomes 1 in the cycle `pred_taken` is 1. It returns to 0 in the cycle `flush` is 1, and flush wins when both occur. Otherwise it holds.
- R9: A taken branch whose index matches a record with a different tag replaces that record. The old branch then misses.
- R10: When a lookup and an update of the same record occur in one cycle, the lookup sees the record as it was before the update. The update is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Branch decoded, lookup request |
| lk_pc | input | ADDR_W | Address of the decoded branch |
| pred_taken | output | 1 | Registered taken prediction |
| pred_target | output | ADDR_W | Registered predicted destination |
| rs_valid | input | 1 | Branch resolved this cycle |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_pipe | input | 1 | Pipe that held the branch, 0 first, 1 second |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | ADDR_W | Actual destination when taken |
| rs_pred_taken | input | 1 | Direction that was predicted for it |
| rs_pred_target | input | ADDR_W | Destination that was predicted for it |
| flush | output | 1 | Pipeline flush request |
| redirect_pc | output | ADDR_W | Restart address for fetch |
| stall_cycles | output | STALL_W | Misprediction penalty in cycles |
| fetch_sel | output | 1 | Prefetch stream select, 1 target, 0 linear |

## Verification
The bench builds the block with `IDX_W = 4`, a 16-record table, and leaves `ADDR_W` at 32. With this table, addresses 0x100 and 0x200 share index 0 but carry different tags. That makes the allocation, eviction and no-allocation rules reachable with a handful of branches. The bench walks one record's counter into both saturation limits and back, which separates saturation from wrap-around. It also drives a lookup and an update of the same record in one cycle, and resolves branches in both pipes.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic {
        PIPE_U = 1'b0,
        PIPE_V = 1'b1
    } pipe_e;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_ALLOC = 2'd2;

    function automatic ctr_t ctr_step(ctr_t c, logic up);
        if (up) begin
            return (c == 2'd3) ? c : c + 2'd1;
        end
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_leans_taken(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output ctr_t              lk_ctr,
    output logic [ADDR_W-1:0] lk_tgt,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_tgt
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - 2;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             up_hit;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
    assign up_idx = up_pc[IDX_W+1:2];
    assign up_tag = up_pc[ADDR_W-1:IDX_W+2];

    // Read of the stored state: same-cycle writes become visible next cycle
    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_ctr = ctr_q[lk_idx];
    assign lk_tgt = tgt_q[lk_idx];
    assign up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (up_valid && !up_hit && up_taken) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && up_valid) begin
            if (up_hit) begin
                ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
                if (up_taken) begin
                    tgt_q[up_idx] <= up_tgt;
                end
            end else if (up_taken) begin
                tag_q[up_idx] <= up_tag;
                tgt_q[up_idx] <= up_tgt;
                ctr_q[up_idx] <= CTR_ALLOC;
            end
        end
    end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STALL_W    = 3,
    parameter int U_PENALTY  = 3,
    parameter int V_PENALTY  = 4,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rs_valid,
    input  logic [ADDR_W-1:0]  rs_pc,
    input  pipe_e              rs_pipe,
    input  logic               rs_taken,
    input  logic [ADDR_W-1:0]  rs_target,
    input  logic               rs_pred_taken,
    input  logic [ADDR_W-1:0]  rs_pred_target,
    output logic               mispredict,
    output logic               flush,
    output logic [ADDR_W-1:0]  redirect_pc,
    output logic [STALL_W-1:0] stall_cycles
);
    logic [ADDR_W-1:0]  correct_pc;
    logic [STALL_W-1:0] penalty;

    assign mispredict = rs_valid &&
                        ((rs_taken != rs_pred_taken) ||
                         (rs_taken && (rs_target != rs_pred_target)));
    assign correct_pc = rs_taken ? rs_target : rs_pc + ADDR_W'(INSN_BYTES);
    assign penalty    = (rs_pipe == PIPE_V) ? STALL_W'(V_PENALTY) : STALL_W'(U_PENALTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush        <= 1'b0;
            redirect_pc  <= '0;
            stall_cycles <= '0;
        end else begin
            flush        <= mispredict;
            redirect_pc  <= mispredict ? correct_pc : '0;
            stall_cycles <= mispredict ? penalty : '0;
        end
    end

endmodule

// File: rtl/btb_fetch_sel.sv
module btb_fetch_sel (
    input  logic clk,
    input  logic rst,
    input  logic to_target,
    input  logic to_linear,
    output logic sel
);
    always_ff @(posedge clk) begin
        if (rst || to_linear) begin
            sel <= 1'b0;
        end else if (to_target) begin
            sel <= 1'b1;
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 8,
    parameter int STALL_W    = 3,
    parameter int U_PENALTY  = 3,
    parameter int V_PENALTY  = 4,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_pc,
    output logic               pred_taken,
    output logic [ADDR_W-1:0]  pred_target,
    input  logic               rs_valid,
    input  logic [ADDR_W-1:0]  rs_pc,
    input  logic               rs_pipe,
    input  logic               rs_taken,
    input  logic [ADDR_W-1:0]  rs_target,
    input  logic               rs_pred_taken,
    input  logic [ADDR_W-1:0]  rs_pred_target,
    output logic               flush,
    output logic [ADDR_W-1:0]  redirect_pc,
    output logic [STALL_W-1:0] stall_cycles,
    output logic               fetch_sel
);
    logic              lk_hit;
    ctr_t              lk_ctr;
    logic [ADDR_W-1:0] lk_tgt;
    logic              guess_taken;
    logic              mispredict;

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (lk_pc),
        .lk_hit   (lk_hit),
        .lk_ctr   (lk_ctr),
        .lk_tgt   (lk_tgt),
        .up_valid (rs_valid),
        .up_pc    (rs_pc),
        .up_taken (rs_taken),
        .up_tgt   (rs_target)
    );

    assign guess_taken = lk_valid && lk_hit && ctr_leans_taken(lk_ctr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_taken  <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_taken  <= guess_taken;
            pred_target <= guess_taken ? lk_tgt : '0;
        end
    end

    btb_resolve #(
        .ADDR_W     (ADDR_W),
        .STALL_W    (STALL_W),
        .U_PENALTY  (U_PENALTY),
        .V_PENALTY  (V_PENALTY),
        .INSN_BYTES (INSN_BYTES)
    ) u_resolve (
        .clk            (clk),
        .rst            (rst),
        .rs_valid       (rs_valid),
        .rs_pc          (rs_pc),
        .rs_pipe        (pipe_e'(rs_pipe)),
        .rs_taken       (rs_taken),
        .rs_target      (rs_target),
        .rs_pred_taken  (rs_pred_taken),
        .rs_pred_target (rs_pred_target),
        .mispredict     (mispredict),
        .flush          (flush),
        .redirect_pc    (redirect_pc),
        .stall_cycles   (stall_cycles)
    );

    btb_fetch_sel u_fetch_sel (
        .clk       (clk),
        .rst       (rst),
        .to_target (guess_taken),
        .to_linear (mispredict),
        .sel       (fetch_sel)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int STALL_W   = 3,
    parameter int U_PENALTY = 3,
    parameter int V_PENALTY = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               rs_valid,
    input logic               rs_pipe,
    input logic               pred_taken,
    input logic               flush,
    input logic [STALL_W-1:0] stall_cycles,
    input logic               fetch_sel
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_taken && !flush && !fetch_sel));

    assert_pred_needs_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> $past(lk_valid));

    assert_flush_needs_resolve_R6: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(rs_valid));

    assert_penalty_by_pipe_R7: assert property (@(posedge clk) disable iff (rst)
        flush |-> (stall_cycles == ($past(rs_pipe) ? STALL_W'(V_PENALTY) : STALL_W'(U_PENALTY))));

    assert_no_stall_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (stall_cycles == '0));

    assert_flush_to_linear_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> !fetch_sel);

    assert_taken_to_target_R8: assert property (@(posedge clk) disable iff (rst)
        (pred_taken && !flush) |-> fetch_sel);

    assert_flush_single_R6: assert property (@(posedge clk) disable iff (rst)
        (flush && !$past(rs_valid, 1)) |-> 1'b0);
endmodule

bind btb_predictor btb_predictor_chk #(
    .STALL_W   (STALL_W),
    .U_PENALTY (U_PENALTY),
    .V_PENALTY (V_PENALTY)
) i_btb_predictor_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .rs_valid     (rs_valid),
    .rs_pipe      (rs_pipe),
    .pred_taken   (pred_taken),
    .flush        (flush),
    .stall_cycles (stall_cycles),
    .fetch_sel    (fetch_sel)
);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic          pred_taken;
    logic [AW-1:0] pred_target;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_pc = '0;
    logic          rs_pipe = 1'b0;
    logic          rs_taken = 1'b0;
    logic [AW-1:0] rs_target = '0;
    logic          rs_pred_taken = 1'b0;
    logic [AW-1:0] rs_pred_target = '0;
    logic          flush;
    logic [AW-1:0] redirect_pc;
    logic [2:0]    stall_cycles;
    logic          fetch_sel;

    btb_predictor #(.ADDR_W(AW), .IDX_W(4)) i_btb_predictor (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_pipe(rs_pipe),
        .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
        .flush(flush), .redirect_pc(redirect_pc),
        .stall_cycles(stall_cycles), .fetch_sel(fetch_sel)
    );

    always #4 clk = ~clk;

    typedef struct {
        int            due;
        logic          pt;
        logic [AW-1:0] ptg;
        logic          fl;
        logic [AW-1:0] rd;
        logic [2:0]    st;
        logic          fs;
        string         req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor: compares outputs with queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "pred_taken", AW'(pred_taken), AW'(e.pt));
            if (e.pt) chk(e.req, "pred_target", pred_target, e.ptg);
            chk(e.req, "flush", AW'(flush), AW'(e.fl));
            if (e.fl) chk(e.req, "redirect_pc", redirect_pc, e.rd);
            chk(e.req, "stall_cycles", AW'(stall_cycles), AW'(e.st));
            chk(e.req, "fetch_sel", AW'(fetch_sel), AW'(e.fs));
        end
    end

    // Driver: one cycle of stimulus, expectation due one registered stage later
    task automatic step(input logic lv, input logic [AW-1:0] lpc,
                        input logic rv, input logic [AW-1:0] rpc, input logic rt,
                        input logic [AW-1:0] rtg, input logic rp, input logic rpt,
                        input logic [AW-1:0] rptg,
                        input logic ept, input logic [AW-1:0] eptg, input logic efl,
                        input logic [AW-1:0] erd, input logic [2:0] est, input logic efs,
                        input string req);
        exp_t e;
        lk_valid = lv; lk_pc = lpc;
        rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg;
        rs_pipe = rp; rs_pred_taken = rpt; rs_pred_target = rptg;
        e.due = cyc + 1; e.pt = ept; e.ptg = eptg; e.fl = efl; e.rd = erd;
        e.st = est; e.fs = efs; e.req = req;
        q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0; rs_valid = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] pc, input logic ept, input logic [AW-1:0] eptg,
                        input logic efs, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, ept, eptg, 1'b0, '0, 3'd0, efs, req);
    endtask

    task automatic res(input logic [AW-1:0] pc, input logic t, input logic [AW-1:0] tg,
                       input logic pipe, input logic pt, input logic [AW-1:0] ptg,
                       input logic efl, input logic [AW-1:0] erd, input logic [2:0] est,
                       input logic efs, input string req);
        step(1'b0, '0, 1'b1, pc, t, tg, pipe, pt, ptg, 1'b0, '0, efl, erd, est, efs, req);
    endtask

    task automatic idle(input logic efs, input string req);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 3'd0, efs, req);
    endtask

    localparam logic [AW-1:0] A = 32'h100;   // index 0
    localparam logic [AW-1:0] B = 32'h200;   // index 0, different tag

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1'b0, "R1");                                             // reset state
        look(A, 1'b0, '0, 1'b0, "R1 R2");                             // empty table
        res(A, 1, 32'h800, 0, 0, '0, 1, 32'h800, 3'd3, 1'b0, "R6 R7 r4_alloc");
        look(A, 1'b1, 32'h800, 1'b1, "R3 R4 R8");
        res(A, 1, 32'h800, 1, 1, 32'h800, 0, '0, 3'd0, 1'b1, "R7 no flush");
        res(A, 0, '0, 1, 1, 32'h800, 1, 32'h104, 3'd4, 1'b0, "R6 R7 R8");
        res(A, 0, '0, 0, 0, '0, 0, '0, 3'd0, 1'b0, "R5");
        look(A, 1'b0, '0, 1'b0, "R3 R5 counter 1");
        res(A, 1, 32'h900, 0, 0, '0, 1, 32'h900, 3'd3, 1'b0, "R6");
        look(A, 1'b1, 32'h900, 1'b1, "R5 target rewrite");
        res(B, 0, '0, 0, 0, '0, 0, '0, 3'd0, 1'b1, "R4");
        look(B, 1'b0, '0, 1'b1, "R4 no alloc");
        look(A, 1'b1, 32'h900, 1'b1, "R4 neighbour intact");
        res(B, 1, 32'hA00, 1, 0, '0, 1, 32'hA00, 3'd4, 1'b0, "R9 R7");
        look(A, 1'b0, '0, 1'b0, "R9 evicted");
        look(B, 1'b1, 32'hA00, 1'b1, "R9");
        // same-cycle lookup and update of one record; flush beats the taken guess
        step(1'b1, B, 1'b1, B, 1'b0, '0, 1'b0, 1'b1, 32'hA00,
             1'b1, 32'hA00, 1'b1, 32'h204, 3'd3, 1'b0, "R10 R8");
        look(B, 1'b0, '0, 1'b0, "R10 update visible");
        // lower saturation: 1 -> 0 -> 0 -> 1 -> 2
        res(B, 0, '0, 0, 0, '0, 0, '0, 3'd0, 1'b0, "R5");
        res(B, 0, '0, 0, 0, '0, 0, '0, 3'd0, 1'b0, "R5");
        res(B, 1, 32'hA00, 0, 0, '0, 1, 32'hA00, 3'd3, 1'b0, "R5");
        res(B, 1, 32'hA00, 0, 0, '0, 1, 32'hA00, 3'd3, 1'b0, "R5");
        look(B, 1'b1, 32'hA00, 1'b1, "R5 floor saturation");
        // upper saturation: 2 -> 3 -> 3 -> 3 -> 2
        res(B, 1, 32'hA00, 0, 1, 32'hA00, 0, '0, 3'd0, 1'b1, "R5");
        res(B, 1, 32'hA00, 0, 1, 32'hA00, 0, '0, 3'd0, 1'b1, "R5");
        res(B, 1, 32'hA00, 0, 1, 32'hA00, 0, '0, 3'd0, 1'b1, "R5");
        res(B, 0, '0, 1, 1, 32'hA00, 1, 32'h204, 3'd4, 1'b0, "R6 R7");
        look(B, 1'b1, 32'hA00, 1'b1, "R5 ceiling saturation");
        // wrong destination with right direction
        res(B, 1, 32'hB00, 1, 1, 32'hA00, 1, 32'hB00, 3'd4, 1'b0, "R6 target mismatch");
        look(B, 1'b1, 32'hB00, 1'b1, "R5");
        idle(1'b1, "R2 no lookup");
        // reset mid-run clears the table
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(1'b0, "R1");
        look(B, 1'b0, '0, 1'b0, "R1 table cleared");
        idle(1'b0, "R1");
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule